// File: doc/BRIEF.md
# Floating-Point Immediate Load Unit

This unit executes two floating-point immediate instructions that share one 32-bit format. The first, load-high, places a 16-bit immediate in the upper half of a single-precision word with a zero lower half. It widens that word to double precision and writes it to a 64-bit FP register. The second, patch-low, first narrows the target register's double value back to single precision and keeps the top 16 bits of that word (sign, exponent and the top seven mantissa bits). It joins those bits with a new 16-bit immediate as the lower half, widens the result to double and writes it back to the same register. Issuing load-high and then patch-low loads any single-precision constant. The register file has 32 entries and a separate combinational read port for observation.

Instructions arrive on a valid/ready stream. A word moves on a clock edge where `insn_valid` and `insn_ready` are both high. The unit executes it and writes the register on the next edge. `insn_ready` stays low for the cycle in between, so the unit takes at most one instruction every two cycles. A sender that sees `insn_ready` low must hold its word and keep `insn_valid` high until the word is taken. Words that do not decode raise a one-cycle illegal pulse and write no register. Every accepted word advances the program counter by 4.

Top module: `fimm_unit`

## Requirements
- R1: Bit numbering is MSB-first, so instruction bit i is `insn_word[31-i]`. The primary opcode is in bits 0-5 and the target register in bits 6-10. The immediate is scattered over three fields: bits 16-25 give immediate bits 15..6, bits 11-15 give immediate bits 5..1, and bit 31 gives immediate bit 0. The extended opcode is in bits 26-30.
- R2: Primary opcode 22 with extended opcode 5'b00011 is load-high. It writes the double-precision form of the single-precision word {imm, 16'h0000} to the target register.
- R3: Primary opcode 22 with extended opcode 5'b01011 is patch-low. It narrows the register's current value to single precision and keeps the top 16 bits of that word. It appends the immediate as the lower 16 bits and writes the double-precision form of the result back to the same register.
- R4: When widening, a normal single-precision value keeps its sign and fraction, and its exponent field is increased by 896.
- R5: A single-precision zero or infinity widens to a double zero or infinity of the same sign.
- R6: A single-precision NaN widens to a double with an all-ones exponent and the 23-bit fraction placed in the top of the 52-bit fraction. Narrowing a NaN gives a NaN.
- R7: A subnormal single-precision value is normalized by a leading-zero shift. Its double exponent field is 896 minus the number of leading zeros in the 23-bit fraction.
- R8: Any other accepted word sets `illegal` high for exactly one cycle and leaves every register unchanged.
- R9: Every accepted word, legal or not, increases `pc` by 4 on the edge that executes it.
- R10: After an accepting edge, `insn_ready` is low for one cycle. The register write, the `illegal` pulse and the `pc` update all appear after the next edge.
- R11: After reset, every register reads zero, `pc` is 0, `illegal` is low and `insn_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word is offered |
| insn_ready | output | 1 | Unit can take a word this cycle |
| insn_word | input | 32 | Instruction word |
| rd_addr | input | 5 | Observation read address |
| rd_data | output | 64 | Register contents at `rd_addr`, combinational |
| illegal | output | 1 | One-cycle pulse for an undecodable word |
| pc | output | 64 | Program counter |

## Verification
Each result is due two edges after its word is offered: the accepting edge, then the execute edge. The scoreboard therefore samples the register, the `illegal` pulse and `pc` at the falling edge that follows the execute edge. `insn_ready` is checked low at the falling edge between those two edges. The driver waits until the scoreboard has drained before it offers the next word, so every comparison sees one instruction's effect alone. Hazards between a load-high and a following patch-low cannot occur, because the two-cycle spacing holds back the second word until the first has written its register.

// File: rtl/fimm_pkg.sv
package fimm_pkg;
  localparam logic [5:0] PRIMARY_OP = 6'd22;
  localparam logic [4:0] XO_LOAD_HI = 5'b00011;
  localparam logic [4:0] XO_PATCH_LO = 5'b01011;

  typedef enum logic [1:0] {OP_NONE, OP_LOAD_HI, OP_PATCH_LO, OP_BAD} fimm_op_e;

  typedef struct packed {
    fimm_op_e    op;
    logic [4:0]  frs;
    logic [15:0] imm;
  } fimm_dec_t;
endpackage

// File: rtl/fimm_decode.sv
module fimm_decode
  import fimm_pkg::*;
(
  input  logic [31:0] word,
  output fimm_dec_t   dec
);
  always_comb begin
    dec.frs = word[25:21];
    // scattered immediate: upper ten, middle five, lowest one
    dec.imm = {word[15:6], word[20:16], word[0]};
    if (word[31:26] != PRIMARY_OP) dec.op = OP_BAD;
    else if (word[5:1] == XO_LOAD_HI) dec.op = OP_LOAD_HI;
    else if (word[5:1] == XO_PATCH_LO) dec.op = OP_PATCH_LO;
    else dec.op = OP_BAD;
  end
endmodule

// File: rtl/fimm_widen.sv
module fimm_widen (
  input  logic [31:0] sp,
  output logic [63:0] dp
);
  logic       s;
  logic [7:0] e;
  logic [22:0] m, nm;
  logic [4:0] lz;
  logic       hit;

  always_comb begin
    s = sp[31];
    e = sp[30:23];
    m = sp[22:0];
    lz = '0;
    hit = 1'b0;
    for (int i = 22; i >= 0; i--) begin
      if (!hit && m[i]) begin
        lz = 5'(22 - i);
        hit = 1'b1;
      end
    end
    nm = m << (lz + 5'd1);
    if (e == 8'hFF)
      dp = {s, 11'h7FF, m, 29'b0};
    else if (e == 8'h00) begin
      if (m == '0) dp = {s, 63'b0};
      else dp = {s, 11'd896 - {6'b0, lz}, nm, 29'b0};
    end else
      dp = {s, {3'b0, e} + 11'd896, m, 29'b0};
  end
endmodule

// File: rtl/fimm_narrow_hi.sv
module fimm_narrow_hi (
  input  logic [63:0] dp,
  output logic [15:0] hi
);
  logic        s;
  logic [10:0] e;
  logic [51:0] m;
  logic [10:0] sh;
  logic [23:0] sub;

  always_comb begin
    s = dp[63];
    e = dp[62:52];
    m = dp[51:0];
    sh = 11'd897 - e;
    sub = {1'b1, m[51:29]} >> sh[4:0];
    if (e == 11'h7FF)
      hi = {s, 8'hFF, m[51:45] | {(m != '0) && (m[51:45] == '0), 6'b0}};
    else if (e >= 11'd1151)
      hi = {s, 8'hFF, 7'b0};
    else if (e >= 11'd897)
      hi = {s, 8'(e - 11'd896), m[51:45]};
    else if (sh >= 11'd24)
      hi = {s, 15'b0};
    else
      hi = {s, 8'h00, sub[22:16]};
  end
endmodule

// File: rtl/fimm_regfile.sv
module fimm_regfile #(
  parameter int DEPTH = 32,
  parameter int DW = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra0,
  output logic [DW-1:0] rd0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rd1
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/fimm_unit.sv
module fimm_unit
  import fimm_pkg::*;
#(
  parameter int NUM_FPR = 32,
  parameter int PC_W = 64,
  parameter int PC_STEP = 4,
  localparam int AW = $clog2(NUM_FPR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  output logic            insn_ready,
  input  logic [31:0]     insn_word,
  input  logic [AW-1:0]   rd_addr,
  output logic [63:0]     rd_data,
  output logic            illegal,
  output logic [PC_W-1:0] pc
);
  fimm_dec_t   dec, ex;
  logic        busy, accept, wr_en;
  logic [63:0] cur, wr_data;
  logic [15:0] keep_hi;
  logic [31:0] sp_word;

  fimm_decode u_dec (.word(insn_word), .dec(dec));

  assign insn_ready = !busy;
  assign accept = insn_valid && insn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ex <= '{op: OP_NONE, frs: '0, imm: '0};
      illegal <= 1'b0;
      pc <= '0;
    end else begin
      busy <= accept;
      if (accept) ex <= dec;
      illegal <= busy && (ex.op == OP_BAD);
      if (busy) pc <= pc + PC_W'(PC_STEP);
    end
  end

  fimm_narrow_hi u_nar (.dp(cur), .hi(keep_hi));

  assign sp_word = (ex.op == OP_LOAD_HI) ? {ex.imm, 16'h0000} : {keep_hi, ex.imm};

  fimm_widen u_wid (.sp(sp_word), .dp(wr_data));

  assign wr_en = busy && (ex.op == OP_LOAD_HI || ex.op == OP_PATCH_LO);

  fimm_regfile #(.DEPTH(NUM_FPR), .DW(64)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .wa(ex.frs[AW-1:0]), .wd(wr_data),
    .ra0(ex.frs[AW-1:0]), .rd0(cur),
    .ra1(rd_addr), .rd1(rd_data)
  );
endmodule

// File: rtl/fimm_unit_chk.sv
module fimm_unit_chk #(
  parameter int PC_W = 64,
  parameter int PC_STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_valid,
  input logic            insn_ready,
  input logic            illegal,
  input logic            wr_en,
  input logic [PC_W-1:0] pc
);
  assert_accept_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_ready) |=> !insn_ready);

  assert_write_in_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !insn_ready);

  assert_illegal_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);

  assert_illegal_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !$past(wr_en));

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> pc == $past(pc) + PC_W'(PC_STEP));
endmodule

bind fimm_unit fimm_unit_chk #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
  .illegal(illegal), .wr_en(wr_en), .pc(pc)
);

// File: tb/fimm_unit_bench.sv
module fimm_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        insn_ready;
  logic [31:0] insn_word = '0;
  logic [4:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        illegal;
  logic [63:0] pc;

  int checks = 0;
  int errors = 0;
  logic [63:0] pc_exp = '0;

  typedef struct {
    logic [4:0]  a;
    logic [63:0] d;
    logic        ill;
    logic [63:0] p;
    string       req;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  fimm_unit u_fimm_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn_word(insn_word), .rd_addr(rd_addr), .rd_data(rd_data),
    .illegal(illegal), .pc(pc)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(logic [5:0] po, logic [4:0] xo, logic [4:0] frs,
                                      logic [15:0] imm);
    return {po, frs, imm[5:1], imm[15:6], xo, imm[0]};
  endfunction

  task automatic run(logic [31:0] w, logic [4:0] a, logic [63:0] d, logic ill, string req);
    exp_t e;
    @(negedge clk);
    insn_word = w;
    insn_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
    chk(insn_ready == 1'b0, "R10 ready", 64'(insn_ready), 64'd0);
    pc_exp += 64'd4;
    e.a = a; e.d = d; e.ill = ill; e.p = pc_exp; e.req = req;
    sbq.push_back(e);
    wait (sbq.size() == 0);
  endtask

  // monitor: results due after the execute edge
  initial begin
    exp_t e;
    forever begin
      wait (sbq.size() > 0);
      @(posedge clk);
      @(negedge clk);
      e = sbq.pop_front();
      rd_addr = e.a;
      #1;
      chk(rd_data == e.d, e.req, rd_data, e.d);
      chk(illegal == e.ill, {e.req, " R8 illegal"}, 64'(illegal), 64'(e.ill));
      chk(pc == e.p, "R9 pc", pc, e.p);
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    #1;
    rd_addr = 5'd3;
    #1;
    chk(rd_data == 64'd0, "R11 reg", rd_data, 64'd0);
    chk(pc == 64'd0, "R11 pc", pc, 64'd0);
    chk(illegal == 1'b0, "R11 illegal", 64'(illegal), 64'd0);
    chk(insn_ready == 1'b1, "R11 ready", 64'(insn_ready), 64'd1);

    run(enc(6'd22, 5'b00011, 5'd3, 16'h4049), 5'd3, 64'h4009200000000000, 1'b0, "R2 R4 load");
    run(enc(6'd22, 5'b01011, 5'd3, 16'h0FD0), 5'd3, 64'h400921FA00000000, 1'b0, "R3 patch pi");
    run(enc(6'd22, 5'b00011, 5'd5, 16'h3F80), 5'd5, 64'h3FF0000000000000, 1'b0, "R2 load one");
    run(enc(6'd22, 5'b01011, 5'd5, 16'h4000), 5'd5, 64'h3FF0080000000000, 1'b0, "R3 patch one");
    run(enc(6'd22, 5'b00011, 5'd31, 16'hC2A5), 5'd31, 64'hC054A00000000000, 1'b0, "R1 scatter");
    run(enc(6'd22, 5'b00011, 5'd7, 16'hFF80), 5'd7, 64'hFFF0000000000000, 1'b0, "R5 -inf");
    run(enc(6'd22, 5'b01011, 5'd7, 16'h0001), 5'd7, 64'hFFF0000020000000, 1'b0, "R6 inf to nan");
    run(enc(6'd22, 5'b00011, 5'd6, 16'h7FC0), 5'd6, 64'h7FF8000000000000, 1'b0, "R6 qnan");
    run(enc(6'd22, 5'b00011, 5'd10, 16'h8000), 5'd10, 64'h8000000000000000, 1'b0, "R5 -zero");
    run(enc(6'd22, 5'b00011, 5'd8, 16'h0040), 5'd8, 64'h3800000000000000, 1'b0, "R7 subnormal");
    run(enc(6'd22, 5'b01011, 5'd8, 16'h1234), 5'd8, 64'h3800048D00000000, 1'b0, "R7 R3 sub patch");
    run(enc(6'd22, 5'b01011, 5'd9, 16'h0001), 5'd9, 64'h36A0000000000000, 1'b0, "R7 min sub");
    run(enc(6'd22, 5'b00000, 5'd3, 16'hFFFF), 5'd3, 64'h400921FA00000000, 1'b1, "R8 bad xo");
    run(enc(6'd23, 5'b00011, 5'd5, 16'h0000), 5'd5, 64'h3FF0080000000000, 1'b1, "R8 bad po");

    @(negedge clk);
    chk(illegal == 1'b0, "R8 pulse end", 64'(illegal), 64'd0);
    rd_addr = 5'd0;
    #1;
    chk(rd_data == 64'd0, "R8 untouched r0", rd_data, 64'd0);
    finish_run();
  end
endmodule